// File: doc/BRIEF.md
# Mixed-Radix Hyperbolic Rotation CORDIC

This block turns a signed fixed-point angle into a scaled pair of hyperbolic cosine and sine values. It is meant to feed a later ratio stage, for example one that forms a hyperbolic tangent. That stage divides one output by the other, so the common scale factor cancels and no correction multiplier is needed here. The datapath uses only shifters, adders, subtractors and constant angle values worked out at elaboration time.

Each micro-rotation sits in its own pipeline register stage. The early stages make binary rotations steered by the sign of the residual angle. The final binary index is taken twice, because hyperbolic iterations need that repeat to converge. The later stages make base-4 rotations with a signed digit from -2 to +2, picked by comparing the residual angle against midpoint thresholds. This lets a few stages reach full 14-bit fraction precision. A valid flag moves with the data, so the block takes one sample per clock and returns each result after a fixed latency.

Angles and outputs are 16-bit two's complement with 14 fraction bits, so a code of 16384 means 1.0. The input magnitude is limited to 0.5 (code 8192).

Top module: `hrc_mixed_radix`

## Requirements
- R1: With default parameters, an input accepted on a clock edge with `in_valid` high appears with `out_valid` high exactly 12 rising edges later, counting the accepting edge as the first. Each accepted input gives exactly one output.
- R2: While `rst` is high and on the first cycle after it falls, `out_valid` is low and both data outputs are zero. Samples in flight when reset is applied are discarded.
- R3: For every result, `out_cosh` divided by 16384·cosh(angle) lies between 0.815 and 0.835. That is the residual gain of the micro-rotations, and `out_cosh` is always positive.
- R4: For every result, `out_sinh` differs from `out_cosh`·tanh(angle) by at most 20 LSB, with angle = `in_angle`/16384.
- R5: An angle code of at least +64 gives a positive `out_sinh`, and a code of at most -64 gives a negative `out_sinh`.
- R6: Angles a and -a give `out_cosh` values within 8 LSB of each other, and `out_sinh` values whose sum is within 8 LSB of zero.
- R7: A run of consecutive valid inputs gives the same number of consecutive valid outputs, in input order, with no gaps.
- R8: On any cycle where `out_valid` is low, `out_cosh` and `out_sinh` keep their previous values. `in_angle` has no effect while `in_valid` is low.
- R9: The end points +8192 and -8192 and the zero angle meet R3 and R4. For zero, `out_sinh` is within 20 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_angle` as a sample to process |
| in_angle | input | 16 | Signed angle, 14 fraction bits, magnitude at most 8192 |
| out_valid | output | 1 | Marks a result on the data outputs |
| out_cosh | output | 16 | Scaled hyperbolic cosine, signed, 14 fraction bits |
| out_sinh | output | 16 | Scaled hyperbolic sine, signed, 14 fraction bits |

## Verification
The properties assume that every angle presented with `in_valid` high has a magnitude no greater than 8192. Outside that range the rotations cannot converge, and the sign and positivity properties would have no basis. One property checks this input contract directly. The directed stimulus only draws valid angles from the closed range from -8192 to +8192, including both end points and zero. While `in_valid` is low, it deliberately drives an out-of-range code on `in_angle`, so that the contract is shown to apply only to qualified samples.

// File: rtl/hrc_mr_pkg.sv
`timescale 1ns/1ps
package hrc_mr_pkg;

  typedef enum logic [1:0] {
    DG_ZERO = 2'd0,
    DG_ONE  = 2'd1,
    DG_TWO  = 2'd2
  } r4_digit_e;

  // atanh(2^-s) rounded to 'frac' fraction bits, via the odd power series
  // evaluated in a 48-bit fraction accumulator.
  function automatic int atanh_pow2_q(input int s, input int frac);
    longint acc;
    longint term;
    int     e;
    acc = 0;
    for (int n = 0; n < 24; n++) begin
      e = 48 - s * (2 * n + 1);
      if (e >= 0) begin
        term = (64'sd1 <<< e);
        acc  = acc + term / longint'(2 * n + 1);
      end
    end
    return int'((acc + (64'sd1 <<< (47 - frac))) >>> (48 - frac));
  endfunction

  // Number of binary stages for indices 1..last, including repeated indices
  // (4, 13, 40, ...) that hyperbolic convergence requires.
  function automatic int r2_count(input int last);
    int cnt;
    int nxt;
    cnt = 0;
    nxt = 4;
    for (int k = 1; k <= last; k++) begin
      cnt++;
      if (k == nxt) begin
        cnt++;
        nxt = 3 * nxt + 1;
      end
    end
    return cnt;
  endfunction

  // Shift index used by binary stage position p.
  function automatic int r2_index(input int p);
    int  pos;
    int  nxt;
    int  res;
    bit  found;
    pos   = 0;
    nxt   = 4;
    res   = 1;
    found = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (!found && pos == p) begin
        res   = k;
        found = 1'b1;
      end
      pos++;
      if (k == nxt) begin
        if (!found && pos == p) begin
          res   = k;
          found = 1'b1;
        end
        pos++;
        nxt = 3 * nxt + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hrc_seed.sv
`timescale 1ns/1ps
module hrc_seed #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic signed [W-1:0] ang_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);
  localparam logic signed [W-1:0] UNIT = W'(1) <<< FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= UNIT;
        y_o <= '0;
        z_o <= ang_i;
      end
    end
  end
endmodule

// File: rtl/hrc_r2_stage.sv
`timescale 1ns/1ps
module hrc_r2_stage
  import hrc_mr_pkg::*;
#(
  parameter int W     = 16,
  parameter int FRAC  = 14,
  parameter int SHIFT = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] z_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);
  localparam int                  ALPHA_I = atanh_pow2_q(SHIFT, FRAC);
  localparam logic signed [W-1:0] ALPHA   = ALPHA_I[W-1:0];

  logic                go_up;
  logic signed [W-1:0] xs, ys;
  logic signed [W-1:0] x_n, y_n, z_n;

  always_comb begin
    go_up = ~z_i[W-1];
    xs    = x_i >>> SHIFT;
    ys    = y_i >>> SHIFT;
    if (go_up) begin
      x_n = x_i + ys;
      y_n = y_i + xs;
      z_n = z_i - ALPHA;
    end else begin
      x_n = x_i - ys;
      y_n = y_i - xs;
      z_n = z_i + ALPHA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_n;
        y_o <= y_n;
        z_o <= z_n;
      end
    end
  end
endmodule

// File: rtl/hrc_r4_stage.sv
`timescale 1ns/1ps
module hrc_r4_stage
  import hrc_mr_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int J    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] z_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);
  // digit 1 weight 4^-J = 2^-2J ; digit 2 weight 2*4^-J = 2^-(2J-1)
  localparam int SH1 = 2 * J;
  localparam int SH2 = 2 * J - 1;
  localparam int A1_I = atanh_pow2_q(SH1, FRAC);
  localparam int A2_I = atanh_pow2_q(SH2, FRAC);
  localparam int T1_I = (A1_I + 1) / 2;
  localparam int T2_I = (A1_I + A2_I + 1) / 2;
  localparam logic signed [W-1:0] A1 = A1_I[W-1:0];
  localparam logic signed [W-1:0] A2 = A2_I[W-1:0];
  localparam logic [W-1:0]        T1 = T1_I[W-1:0];
  localparam logic [W-1:0]        T2 = T2_I[W-1:0];

  r4_digit_e           dig;
  logic                neg;
  logic signed [W-1:0] z_neg;
  logic [W-1:0]        mag;
  logic signed [W-1:0] dx, dy, da;
  logic signed [W-1:0] x_n, y_n, z_n;

  always_comb begin
    neg   = z_i[W-1];
    z_neg = -z_i;
    mag   = neg ? z_neg : z_i;
    if (mag >= T2)      dig = DG_TWO;
    else if (mag >= T1) dig = DG_ONE;
    else                dig = DG_ZERO;

    unique case (dig)
      DG_TWO: begin
        dx = y_i >>> SH2;
        dy = x_i >>> SH2;
        da = A2;
      end
      DG_ONE: begin
        dx = y_i >>> SH1;
        dy = x_i >>> SH1;
        da = A1;
      end
      default: begin
        dx = '0;
        dy = '0;
        da = '0;
      end
    endcase

    if (neg) begin
      x_n = x_i - dx;
      y_n = y_i - dy;
      z_n = z_i + da;
    end else begin
      x_n = x_i + dx;
      y_n = y_i + dy;
      z_n = z_i - da;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_n;
        y_o <= y_n;
        z_o <= z_n;
      end
    end
  end
endmodule

// File: rtl/hrc_mixed_radix.sv
`timescale 1ns/1ps
module hrc_mixed_radix
  import hrc_mr_pkg::*;
#(
  parameter int W        = 16,
  parameter int FRAC     = 14,
  parameter int R2_LAST  = 4,
  parameter int R4_FIRST = 2,
  parameter int R4_LAST  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_angle,
  output logic                out_valid,
  output logic signed [W-1:0] out_cosh,
  output logic signed [W-1:0] out_sinh
);
  localparam int N_R2    = r2_count(R2_LAST);
  localparam int N_R4    = R4_LAST - R4_FIRST + 1;
  localparam int N_ST    = N_R2 + N_R4;
  localparam int LATENCY = N_ST + 1;

  logic                v_s [N_ST+1];
  logic signed [W-1:0] x_s [N_ST+1];
  logic signed [W-1:0] y_s [N_ST+1];
  logic signed [W-1:0] z_s [N_ST+1];
  logic signed [W-1:0] z_unused;

  hrc_seed #(.W(W), .FRAC(FRAC)) seed_i (
    .clk   (clk),
    .rst   (rst),
    .v_i   (in_valid),
    .ang_i (in_angle),
    .v_o   (v_s[0]),
    .x_o   (x_s[0]),
    .y_o   (y_s[0]),
    .z_o   (z_s[0])
  );

  for (genvar p = 0; p < N_ST; p++) begin : g_stage
    if (p < N_R2) begin : g_bin
      hrc_r2_stage #(.W(W), .FRAC(FRAC), .SHIFT(r2_index(p))) st_i (
        .clk (clk),
        .rst (rst),
        .v_i (v_s[p]),
        .x_i (x_s[p]),
        .y_i (y_s[p]),
        .z_i (z_s[p]),
        .v_o (v_s[p+1]),
        .x_o (x_s[p+1]),
        .y_o (y_s[p+1]),
        .z_o (z_s[p+1])
      );
    end else begin : g_quad
      hrc_r4_stage #(.W(W), .FRAC(FRAC), .J(R4_FIRST + p - N_R2)) st_i (
        .clk (clk),
        .rst (rst),
        .v_i (v_s[p]),
        .x_i (x_s[p]),
        .y_i (y_s[p]),
        .z_i (z_s[p]),
        .v_o (v_s[p+1]),
        .x_o (x_s[p+1]),
        .y_o (y_s[p+1]),
        .z_o (z_s[p+1])
      );
    end
  end

  assign z_unused  = z_s[N_ST];
  assign out_valid = v_s[N_ST];
  assign out_cosh  = x_s[N_ST];
  assign out_sinh  = y_s[N_ST];
endmodule

// File: rtl/hrc_mixed_radix_chk.sv
`timescale 1ns/1ps
module hrc_mixed_radix_chk
  import hrc_mr_pkg::*;
#(
  parameter int W        = 16,
  parameter int FRAC     = 14,
  parameter int R2_LAST  = 4,
  parameter int R4_FIRST = 2,
  parameter int R4_LAST  = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic signed [W-1:0] in_angle,
  input logic                out_valid,
  input logic signed [W-1:0] out_cosh,
  input logic signed [W-1:0] out_sinh
);
  localparam int LAT = r2_count(R2_LAST) + (R4_LAST - R4_FIRST + 1) + 1;
  localparam logic signed [W-1:0] LIM   = W'(1) <<< (FRAC - 1);
  localparam logic signed [W-1:0] SGN_T = W'(64);

  logic [LAT-1:0]      vsh;
  logic signed [W-1:0] ash [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh <= '0;
      for (int k = 0; k < LAT; k++) ash[k] <= '0;
    end else begin
      vsh    <= {vsh[LAT-2:0], in_valid};
      ash[0] <= in_angle;
      for (int k = 1; k < LAT; k++) ash[k] <= ash[k-1];
    end
  end

  // input contract: qualified angles stay within +/-0.5
  p_angle_range_in: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (in_angle <= LIM && in_angle >= -LIM));

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[LAT-1]);

  p_reset_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_cosh == '0 && out_sinh == '0));

  p_cosh_positive_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cosh > 0);

  p_sinh_pos_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ash[LAT-1] >= SGN_T) |-> out_sinh > 0);

  p_sinh_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ash[LAT-1] <= -SGN_T) |-> out_sinh < 0);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_cosh) && $stable(out_sinh)));
endmodule

bind hrc_mixed_radix hrc_mixed_radix_chk #(
  .W(W), .FRAC(FRAC), .R2_LAST(R2_LAST), .R4_FIRST(R4_FIRST), .R4_LAST(R4_LAST)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_angle  (in_angle),
  .out_valid (out_valid),
  .out_cosh  (out_cosh),
  .out_sinh  (out_sinh)
);

// File: tb/hrc_mixed_radix_tb_top.sv
`timescale 1ns/1ps
module hrc_mixed_radix_tb_top;
  localparam int LAT = 12;
  localparam real ONE = 16384.0;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_angle = '0;
  logic               out_valid;
  logic signed [15:0] out_cosh;
  logic signed [15:0] out_sinh;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int q_ang[$];
  int q_stamp[$];
  int log_ang[$];
  int log_x[$];
  int log_y[$];
  int log_cyc[$];

  always #2 clk = ~clk;

  hrc_mixed_radix dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
    .out_valid(out_valid), .out_cosh(out_cosh), .out_sinh(out_sinh)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic eval_result(input int a, input int x, input int y);
    real ar, g, err;
    ar  = real'(a) / ONE;
    g   = real'(x) / (ONE * $cosh(ar));
    err = real'(y) - real'(x) * $tanh(ar);
    check(g >= 0.815 && g <= 0.835, "R3",
          $sformatf("angle %0d gain actual %f expected 0.815..0.835", a, g));
    check(err <= 20.0 && err >= -20.0, "R4",
          $sformatf("angle %0d sinh actual %0d expected %f", a, y, real'(x) * $tanh(ar)));
    if (a >= 64)
      check(y > 0, "R5", $sformatf("angle %0d sinh actual %0d expected >0", a, y));
    if (a <= -64)
      check(y < 0, "R5", $sformatf("angle %0d sinh actual %0d expected <0", a, y));
  endtask

  // monitor: samples at the falling edge, inputs change 1 ns after rising edges
  always @(negedge clk) begin
    int a, st;
    cyc++;
    if (rst) begin
      q_ang.delete();
      q_stamp.delete();
    end else begin
      if (in_valid) begin
        q_ang.push_back(int'(in_angle));
        q_stamp.push_back(cyc);
      end
      if (out_valid) begin
        if (q_ang.size() == 0) begin
          check(1'b0, "R1", "output actual present expected none pending");
        end else begin
          a  = q_ang.pop_front();
          st = q_stamp.pop_front();
          check(cyc - st == LAT, "R1",
                $sformatf("latency actual %0d expected %0d", cyc - st, LAT));
          eval_result(a, int'(out_cosh), int'(out_sinh));
          log_ang.push_back(a);
          log_x.push_back(int'(out_cosh));
          log_y.push_back(int'(out_sinh));
          log_cyc.push_back(cyc);
        end
      end else if (q_stamp.size() != 0 && cyc - q_stamp[0] >= LAT) begin
        check(1'b0, "R1", $sformatf("missing output for angle %0d actual none expected at %0d",
                                     q_ang[0], q_stamp[0] + LAT));
        void'(q_ang.pop_front());
        void'(q_stamp.pop_front());
      end
    end
  end

  task automatic send(input int a);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_angle = 16'(a);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_angle = 16'sh5A5A; // out-of-range garbage, must be ignored
  endtask

  task automatic drain();
    idle();
    repeat (LAT + 4) @(posedge clk);
  endtask

  task automatic test_reset_state();
    repeat (4) begin
      @(negedge clk);
      check(!out_valid && out_cosh == 0 && out_sinh == 0, "R2",
            $sformatf("in reset valid %0b cosh %0d sinh %0d expected 0 0 0",
                      out_valid, out_cosh, out_sinh));
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && out_cosh == 0 && out_sinh == 0, "R2",
          $sformatf("after reset valid %0b cosh %0d expected 0 0", out_valid, out_cosh));
  endtask

  task automatic test_single();
    int n0;
    n0 = log_ang.size();
    send(3000);
    drain();
    check(log_ang.size() == n0 + 1, "R1",
          $sformatf("single outputs actual %0d expected 1", log_ang.size() - n0));
  endtask

  task automatic test_burst();
    int n0, n;
    bit order_ok;
    n0 = log_ang.size();
    for (int a = -8192; a <= 8192; a += 420) send(a);
    drain();
    n = log_ang.size() - n0;
    check(n == 40, "R7", $sformatf("burst outputs actual %0d expected 40", n));
    if (n == 40) begin
      check(log_cyc[n0 + 39] - log_cyc[n0] == 39, "R7",
            $sformatf("burst span actual %0d expected 39", log_cyc[n0 + 39] - log_cyc[n0]));
      order_ok = 1'b1;
      for (int k = 0; k < 40; k++)
        if (log_ang[n0 + k] != -8192 + 420 * k) order_ok = 1'b0;
      check(order_ok, "R7", "burst order actual mismatched expected input order");
    end
  endtask

  task automatic test_bounds();
    int n0;
    n0 = log_ang.size();
    send(8192);
    send(-8192);
    send(0);
    drain();
    check(log_ang.size() == n0 + 3, "R9",
          $sformatf("bound outputs actual %0d expected 3", log_ang.size() - n0));
    if (log_ang.size() == n0 + 3) begin
      check(log_y[n0] > 0 && log_y[n0 + 1] < 0, "R9",
            $sformatf("end-point sinh actual %0d %0d expected +/-", log_y[n0], log_y[n0 + 1]));
      check(log_y[n0 + 2] <= 20 && log_y[n0 + 2] >= -20, "R9",
            $sformatf("zero sinh actual %0d expected 0", log_y[n0 + 2]));
      check(log_x[n0 + 2] >= 13353 && log_x[n0 + 2] <= 13681, "R9",
            $sformatf("zero cosh actual %0d expected 13353..13681", log_x[n0 + 2]));
    end
  endtask

  task automatic test_symmetry();
    int vals[6] = '{100, 1000, 3000, 4321, 6000, 8000};
    int n0, dx, sy;
    n0 = log_ang.size();
    foreach (vals[k]) begin
      send(vals[k]);
      send(-vals[k]);
    end
    drain();
    check(log_ang.size() == n0 + 12, "R6",
          $sformatf("pair outputs actual %0d expected 12", log_ang.size() - n0));
    if (log_ang.size() == n0 + 12) begin
      for (int k = 0; k < 6; k++) begin
        dx = log_x[n0 + 2 * k] - log_x[n0 + 2 * k + 1];
        sy = log_y[n0 + 2 * k] + log_y[n0 + 2 * k + 1];
        check(dx <= 8 && dx >= -8, "R6",
              $sformatf("angle %0d cosh diff actual %0d expected 0", vals[k], dx));
        check(sy <= 8 && sy >= -8, "R6",
              $sformatf("angle %0d sinh sum actual %0d expected 0", vals[k], sy));
      end
    end
  endtask

  task automatic test_gaps();
    int n0;
    n0 = log_ang.size();
    send(-5000); idle();
    send(2500);  idle(); idle(); idle();
    send(-700);  send(7000); idle();
    send(1);
    drain();
    check(log_ang.size() == n0 + 5, "R1",
          $sformatf("gapped outputs actual %0d expected 5", log_ang.size() - n0));
  endtask

  task automatic test_hold();
    int lx, ly;
    send(-2222);
    drain();
    lx = log_x[log_x.size() - 1];
    ly = log_y[log_y.size() - 1];
    repeat (10) begin
      @(posedge clk); #1 in_angle = in_angle + 16'sd977;
      @(negedge clk);
      check(!out_valid && out_cosh == lx && out_sinh == ly, "R8",
            $sformatf("idle valid %0b cosh %0d sinh %0d expected 0 %0d %0d",
                      out_valid, out_cosh, out_sinh, lx, ly));
    end
  endtask

  task automatic test_mid_reset();
    for (int k = 0; k < 5; k++) send(1000 * k);
    idle();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1 rst = 1'b0;
    repeat (LAT + 4) begin
      @(negedge clk);
      check(!out_valid, "R2", $sformatf("flushed valid actual %0b expected 0", out_valid));
    end
  endtask

  initial begin
    test_reset_state();
    test_single();
    test_burst();
    test_bounds();
    test_symmetry();
    test_gaps();
    test_hold();
    test_mid_reset();
    test_single();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run actual unfinished expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule